// File: doc/BRIEF.md
# Sequence-Checked Watchdog Kick Qualifier

This block stands between two software strobes and the clear input of a watchdog counter. Software pulses `adv_i` at the start of each program iteration. It pulses `val_i` just before it wants to clear the watchdog. The block forwards a kick only when every validate is matched by exactly one advance.

It checks the pairing with two wrapping accumulators. A current-state register steps by a fixed constant on each advance. An expected-state register steps by the same constant on each validate. After the validate update, the expected value is compared against the current value; equal values mean the pairing held.

When a validate finds a mismatch, no kick is sent, so the watchdog is left to expire. A sticky fault flag is also raised. While that flag is set, every later validate is refused.

Top module: `seq_kick_gate`

## Requirements
- R1: After reset, `kick_o` and `fault_o` are 0 and both accumulators hold 0, so a first advance followed by a validate produces a kick.
- R2: Each cycle with `adv_i` high adds STEP (default 16'h1111) to the current-state register. An advance on its own never produces a kick or a fault.
- R3: Each cycle with `val_i` high adds STEP to the expected-state register. It then compares the updated expected value with the current value, updated by any advance in the same cycle.
- R4: When that comparison matches and no fault is held, `kick_o` is high for exactly the one cycle after the validate.
- R5: When that comparison mismatches, `kick_o` stays 0 and `fault_o` goes high on the cycle after the validate.
- R6: Two validates with no advance between them make the second one mismatch, which raises the fault with no kick.
- R7: `fault_o` is sticky until reset. While it is set, even a matching validate produces no kick.
- R8: When `adv_i` and `val_i` are high in the same cycle, the advance is applied before the comparison.
- R9: Both accumulators wrap modulo 2^W, so balanced pairs keep kicking past the wrap point.
- R10: Without a validate in the previous cycle, `kick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Advance strobe, one per iteration start |
| val_i | input | 1 | Validate strobe, requests a kick |
| kick_o | output | 1 | One-cycle watchdog clear pulse |
| fault_o | output | 1 | Sticky sequence fault flag |

## Verification
The bench drives advance and validate in the same cycle, with the pairing both balanced and one advance ahead. A design that ordered these two updates wrongly would report a false fault in the balanced case, or kick when it should not in the other.

It repeats a validate with no advance between, which must fault. An accumulator that was simply cleared after each kick would miss this.

It sends a matching validate after a fault has been latched, which must stay silent. It also runs more than sixteen balanced pairs to cross the 16-bit wrap, and confirms that reset clears the fault.

// File: rtl/seq_kick_gate.sv
module seq_kick_gate #(
  parameter int           W    = 16,
  parameter logic [W-1:0] STEP = 16'h1111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic val_i,
  output logic kick_o,
  output logic fault_o
);
  logic [W-1:0] cur_q, exp_q;
  logic         kick_q, fault_q;

  wire [W-1:0] cur_nx = adv_i ? cur_q + STEP : cur_q;
  wire [W-1:0] exp_nx = val_i ? exp_q + STEP : exp_q;
  wire         match  = (cur_nx == exp_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      exp_q   <= '0;
      kick_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      cur_q  <= cur_nx;
      exp_q  <= exp_nx;
      kick_q <= val_i && match && !fault_q;
      if (val_i && !match) fault_q <= 1'b1;
    end
  end

  assign kick_o  = kick_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/seq_kick_gate_chk.sv
module seq_kick_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic adv_i,
  input logic val_i,
  input logic kick_o,
  input logic fault_o
);
  a_r10_kick_needs_val: assert property (@(posedge clk) disable iff (!rst_n)
    !val_i |=> !kick_o);
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);
  a_r7_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !kick_o);
  a_r5_fault_after_val: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_o && !val_i) |=> !fault_o);
  a_r5_no_kick_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> !kick_o);
  a_r2_adv_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !val_i && !fault_o) |=> (!kick_o && !fault_o));
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!kick_o && !fault_o));
endmodule

bind seq_kick_gate seq_kick_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .val_i(val_i),
  .kick_o(kick_o), .fault_o(fault_o)
);

// File: tb/seq_kick_gate_test.sv
module seq_kick_gate_test;
  logic clk = 1'b0, rst_n = 1'b0, adv = 1'b0, val = 1'b0;
  logic kick, fault;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seq_kick_gate uut (.clk(clk), .rst_n(rst_n), .adv_i(adv), .val_i(val),
                     .kick_o(kick), .fault_o(fault));

  // fields: [3] adv, [2] val, [1] expected kick, [0] expected fault (next cycle)
  localparam int NV = 12;
  localparam logic [3:0] VEC [NV] = '{
    4'b1000, 4'b0110, 4'b0000, 4'b1110, 4'b1110, 4'b1000,
    4'b0000, 4'b0110, 4'b1000, 4'b1101, 4'b1101, 4'b0001
  };

  task automatic chk(input logic ek, input logic ef, input string req);
    checks++;
    if (kick !== ek || fault !== ef) begin
      fails++;
      $display("FAIL %s: kick=%0b fault=%0b expected kick=%0b fault=%0b",
               req, kick, fault, ek, ef);
    end
  endtask

  task automatic step(input logic a, input logic v);
    adv = a; val = v;
    @(negedge clk);
    adv = 1'b0; val = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(1'b0, 1'b0, "R1 reset state");

    // Table walk: R2, R3, R4, R8, R5, R7
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2]);
      chk(VEC[i][1], VEC[i][0], $sformatf("R2/R3/R4/R5/R7/R8 vector %0d", i));
    end

    // R1: reset clears the fault, and the accumulators restart at zero
    do_reset();
    chk(1'b0, 1'b0, "R1 fault cleared by reset");
    step(1'b1, 1'b0); chk(1'b0, 1'b0, "R2 advance alone");
    step(1'b0, 1'b1); chk(1'b1, 1'b0, "R1 first pair kicks");
    step(1'b0, 1'b0); chk(1'b0, 1'b0, "R4 kick lasts one cycle");
    step(1'b0, 1'b0); chk(1'b0, 1'b0, "R10 idle no kick");

    // R9: balanced pairs across the 16-bit wrap
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      chk(1'b1, 1'b0, $sformatf("R9 wrap pair %0d", k));
    end
    for (int k = 0; k < 18; k++) begin
      step(1'b1, 1'b1);
      chk(1'b1, 1'b0, $sformatf("R8 R9 same-cycle pair %0d", k));
    end

    // R6: two validates in a row
    step(1'b1, 1'b0);
    step(1'b0, 1'b1); chk(1'b1, 1'b0, "R6 first validate kicks");
    step(1'b0, 1'b1); chk(1'b0, 1'b1, "R6 repeated validate faults");

    // R7: validate first faults, then a matching validate is still blocked
    do_reset();
    step(1'b0, 1'b1); chk(1'b0, 1'b1, "R5 validate before advance");
    step(1'b1, 1'b0); chk(1'b0, 1'b1, "R7 fault held");
    step(1'b1, 1'b0);
    step(1'b0, 1'b1); chk(1'b0, 1'b1, "R7 matching validate blocked");

    do_reset();
    step(1'b1, 1'b1); chk(1'b1, 1'b0, "R8 same-cycle first pair");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule